// File: doc/BRIEF.md
# Time and Calendar Update Engine

This block keeps the seven time and calendar bytes of a real-time clock (seconds, minutes, hours, day of week, date, month, year) and three alarm bytes (seconds, minutes, hours). Every accepted one-second tick moves the time forward by one second. Carries run from seconds up to the year. Date rollover follows the length of each month and leap years. Right after the advance, the new time is compared against the alarm bytes, and a match raises a one-cycle alarm pulse.

A host reaches all ten bytes through a byte-wide register port. The byte at the current address is always on the read port, so reads are never blocked. Two mode inputs choose the number format and the hour format, and all ten bytes share that number format. Before rewriting the time, the host raises a hold input, which stops tick updates. It drops the hold afterwards.

Top module: `rtc_calendar_core`

## Requirements
- R1: After a synchronous active-low reset, the byte values are as follows. Seconds, minutes, hours and year read 0x00. Day of week, date and month read 0x01. The three alarm bytes read 0x00. The alarm pulse is low. Addresses 10 to 15 always read 0x00.
- R2: The byte map is fixed: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes, 9 alarm hours. A write lands on the clock edge that samples the strobe. The read data shows the addressed byte combinationally. With no accepted tick and no write, no byte changes.
- R3: Seconds and minutes count 0 to 59 and then wrap to 0, carrying into the next field. The encoding depends on the number-format input. When it is 0, the byte holds packed decimal, tens in bits 7:4 and units in bits 3:0. When it is 1, the byte holds a plain binary number.
- R4: In 24-hour mode (hour-format input 0), the hours count 0 to 23. Wrapping from 23 to 0 carries into the day fields.
- R5: In 12-hour mode (hour-format input 1), bit 7 of the hours byte is the PM flag and bits 6:0 hold the hour, 1 to 12. The sequence is 12 AM, 1 to 11 AM, 12 PM, 1 to 11 PM, then back to 12 AM. The flag toggles on the 11-to-12 step. The day fields advance only on the step from 11 PM to 12 AM.
- R6: Day of week counts 1 to 7 (1 = Sunday). It steps together with the date and wraps from 7 to 1.
- R7: The date rolls to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year value (0 to 99) is divisible by 4, and 28 otherwise. All other months have 31 days. Month 12 wraps to 1 and increments the year, and the year wraps from 99 to 0.
- R8: A tick is dropped, and no time byte changes, when the hold input is 1 or when a write strobe is present in the same cycle. Writes still take effect while the hold input is 1.
- R9: The alarm pulse is high for exactly the one cycle after the edge that applied an accepted tick. It rises only when the new seconds, minutes and hours bytes all equal their alarm bytes, compared as whole bytes including bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| set_hold | input | 1 | Holds off tick updates while 1 |
| bin_mode | input | 1 | 1 = binary bytes, 0 = packed decimal bytes |
| hr12_mode | input | 1 | 1 = 12-hour with PM flag, 0 = 24-hour |
| wr_en | input | 1 | Write strobe for the addressed byte |
| addr | input | ADDR_W | Byte address for both read and write |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Addressed byte, combinational |
| alarm_pulse | output | 1 | One-cycle alarm match pulse |

## Verification
A tick raised at one falling edge is applied at the next rising edge. That rising edge both updates the time bytes and sets the alarm pulse, so both results are due half a cycle after it. A write is due at the same rising edge as its strobe. Reads are combinational, so the scoreboard monitor sets the address at a falling edge and samples the read data a short delay later, after the driver has already waited out the updating edge. The alarm check samples the pulse at the falling edge right after the tick edge. It also counts pulses over the following idle cycles to confirm that the pulse lasts a single cycle and that a tick with no match raises none.

// File: rtl/rtc_pkg.sv
// Shared conversions for the time and calendar engine.
// Assumes every stored byte holds a number from 0 to 99 in the selected format.
package rtc_pkg;
    localparam int BYTE_W = 8;
    localparam int NUM_W  = 7;

    // Decode a stored byte to a plain number.
    function automatic logic [NUM_W-1:0] to_num(input logic [BYTE_W-1:0] v, input logic bin);
        logic [NUM_W-1:0] r;
        if (bin) r = v[NUM_W-1:0];
        else     r = NUM_W'(v[7:4]) * NUM_W'(10) + NUM_W'(v[3:0]);
        return r;
    endfunction

    // Encode a plain number into the selected byte format.
    function automatic logic [BYTE_W-1:0] to_byte(input logic [NUM_W-1:0] n, input logic bin);
        logic [BYTE_W-1:0] r;
        if (bin) r = {1'b0, n};
        else     r = {4'(n / NUM_W'(10)), 4'(n % NUM_W'(10))};
        return r;
    endfunction

    // Number of days in a month; the year is a two-digit value.
    function automatic logic [NUM_W-1:0] month_days(input logic [NUM_W-1:0] m, input logic [NUM_W-1:0] y);
        logic [NUM_W-1:0] r;
        case (m)
            NUM_W'(2):  r = ((y % NUM_W'(4)) == '0) ? NUM_W'(29) : NUM_W'(28);
            NUM_W'(4), NUM_W'(6), NUM_W'(9), NUM_W'(11): r = NUM_W'(30);
            default:    r = NUM_W'(31);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/rtc_wrap_step.sv
// One modulo counter stage (seconds or minutes).
// Steps from LO to HI and wraps to LO, raising carry on the wrap. Assumes cur is in range.
module rtc_wrap_step
    import rtc_pkg::*;
#(
    parameter int LO = 0,
    parameter int HI = 59
) (
    input  logic [BYTE_W-1:0] cur,
    input  logic              bin_mode,
    input  logic              en,
    output logic [BYTE_W-1:0] nxt,
    output logic              carry
);
    logic [NUM_W-1:0] num;

    // Next value of this stage and its carry out.
    always_comb begin
        num   = to_num(cur, bin_mode);
        carry = en && (num == NUM_W'(HI));
        if (!en)        nxt = cur;
        else if (carry) nxt = to_byte(NUM_W'(LO), bin_mode);
        else            nxt = to_byte(num + NUM_W'(1), bin_mode);
    end
endmodule

// File: rtl/rtc_hour_step.sv
// Hour stage for 24-hour and 12-hour formats.
// In 12-hour mode bit 7 is the PM flag. Raises day_carry at midnight.
module rtc_hour_step
    import rtc_pkg::*;
(
    input  logic [BYTE_W-1:0] cur,
    input  logic              bin_mode,
    input  logic              hr12,
    input  logic              en,
    output logic [BYTE_W-1:0] nxt,
    output logic              day_carry
);
    logic [NUM_W-1:0]  hnum;
    logic              pm;
    logic [BYTE_W-1:0] enc;

    // Hour successor and midnight carry.
    always_comb begin
        pm        = cur[7];
        hnum      = to_num(hr12 ? {1'b0, cur[6:0]} : cur, bin_mode);
        day_carry = 1'b0;
        enc       = '0;
        nxt       = cur;
        if (en) begin
            if (!hr12) begin
                if (hnum == NUM_W'(23)) begin
                    nxt       = to_byte('0, bin_mode);
                    day_carry = 1'b1;
                end else begin
                    nxt = to_byte(hnum + NUM_W'(1), bin_mode);
                end
            end else if (hnum == NUM_W'(12)) begin
                enc = to_byte(NUM_W'(1), bin_mode);
                nxt = {pm, enc[6:0]};
            end else if (hnum == NUM_W'(11)) begin
                enc       = to_byte(NUM_W'(12), bin_mode);
                nxt       = {~pm, enc[6:0]};
                day_carry = pm;
            end else begin
                enc = to_byte(hnum + NUM_W'(1), bin_mode);
                nxt = {pm, enc[6:0]};
            end
        end
    end
endmodule

// File: rtl/rtc_date_step.sv
// Day-of-week, date, month and year stage.
// Applies month length and leap years when en (the midnight carry) is high.
module rtc_date_step
    import rtc_pkg::*;
#(
    parameter int WEEK_DAYS  = 7,
    parameter int YEAR_LAST  = 99,
    parameter int YEAR_MONTHS = 12
) (
    input  logic [BYTE_W-1:0] dow,
    input  logic [BYTE_W-1:0] date,
    input  logic [BYTE_W-1:0] month,
    input  logic [BYTE_W-1:0] year,
    input  logic              bin_mode,
    input  logic              en,
    output logic [BYTE_W-1:0] dow_n,
    output logic [BYTE_W-1:0] date_n,
    output logic [BYTE_W-1:0] month_n,
    output logic [BYTE_W-1:0] year_n
);
    logic [NUM_W-1:0] d_num, dt_num, m_num, y_num, last_day;

    // Calendar successor for one elapsed day.
    always_comb begin
        d_num    = to_num(dow, bin_mode);
        dt_num   = to_num(date, bin_mode);
        m_num    = to_num(month, bin_mode);
        y_num    = to_num(year, bin_mode);
        last_day = month_days(m_num, y_num);
        dow_n    = dow;
        date_n   = date;
        month_n  = month;
        year_n   = year;
        if (en) begin
            dow_n = (d_num >= NUM_W'(WEEK_DAYS)) ? to_byte(NUM_W'(1), bin_mode)
                                                 : to_byte(d_num + NUM_W'(1), bin_mode);
            if (dt_num >= last_day) begin
                date_n = to_byte(NUM_W'(1), bin_mode);
                if (m_num >= NUM_W'(YEAR_MONTHS)) begin
                    month_n = to_byte(NUM_W'(1), bin_mode);
                    year_n  = (y_num >= NUM_W'(YEAR_LAST)) ? to_byte('0, bin_mode)
                                                           : to_byte(y_num + NUM_W'(1), bin_mode);
                end else begin
                    month_n = to_byte(m_num + NUM_W'(1), bin_mode);
                end
            end else begin
                date_n = to_byte(dt_num + NUM_W'(1), bin_mode);
            end
        end
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Whole-byte equality of the three time fields against the alarm bytes.
// Assumes both sides use the same number and hour format.
module rtc_alarm_match
    import rtc_pkg::*;
#(
    parameter int FIELDS = 3
) (
    input  logic [FIELDS-1:0][BYTE_W-1:0] now_b,
    input  logic [FIELDS-1:0][BYTE_W-1:0] alm_b,
    output logic                          hit
);
    logic [FIELDS-1:0] eq;

    genvar g;
    for (g = 0; g < FIELDS; g++) begin : g_cmp
        // Per-field equality.
        assign eq[g] = (now_b[g] == alm_b[g]);
    end

    // All fields must agree.
    assign hit = &eq;
endmodule

// File: rtl/rtc_calendar_core.sv
// Time and calendar update engine: ten host-visible bytes advanced by a one-second tick.
// Assumes tick_1hz is a single-cycle pulse and that the host writes only valid values.
// A write strobe or set_hold drops the tick of that cycle.
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              set_hold,
    input  logic              bin_mode,
    input  logic              hr12_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              alarm_pulse
);
    localparam int NUM_REGS  = 10;
    localparam int TIME_REGS = 7;
    localparam int I_HOUR = 2, I_DOW = 3, I_DATE = 4, I_MON = 5, I_YEAR = 6;
    localparam int I_ASEC = 7, I_AMIN = 8, I_AHR = 9;
    localparam int MS_STAGES = 2;

    logic [BYTE_W-1:0] regs [NUM_REGS];
    logic [BYTE_W-1:0] nxt  [TIME_REGS];
    logic [MS_STAGES:0] carry_c;
    logic              step_en, day_en, hit;

    // A tick counts only with no hold and no write in the same cycle.
    assign step_en    = tick_1hz && !set_hold && !wr_en;
    assign carry_c[0] = step_en;

    genvar g;
    for (g = 0; g < MS_STAGES; g++) begin : g_ms
        rtc_wrap_step #(.LO(0), .HI(59)) u_stage (
            .cur      (regs[g]),
            .bin_mode (bin_mode),
            .en       (carry_c[g]),
            .nxt      (nxt[g]),
            .carry    (carry_c[g+1])
        );
    end

    rtc_hour_step u_hour (
        .cur       (regs[I_HOUR]),
        .bin_mode  (bin_mode),
        .hr12      (hr12_mode),
        .en        (carry_c[MS_STAGES]),
        .nxt       (nxt[I_HOUR]),
        .day_carry (day_en)
    );

    rtc_date_step u_date (
        .dow      (regs[I_DOW]),
        .date     (regs[I_DATE]),
        .month    (regs[I_MON]),
        .year     (regs[I_YEAR]),
        .bin_mode (bin_mode),
        .en       (day_en),
        .dow_n    (nxt[I_DOW]),
        .date_n   (nxt[I_DATE]),
        .month_n  (nxt[I_MON]),
        .year_n   (nxt[I_YEAR])
    );

    rtc_alarm_match #(.FIELDS(3)) u_alarm (
        .now_b ({nxt[I_HOUR], nxt[1], nxt[0]}),
        .alm_b ({regs[I_AHR], regs[I_AMIN], regs[I_ASEC]}),
        .hit   (hit)
    );

    // Reset value of each byte: day of week, date and month start at 1.
    function automatic logic [BYTE_W-1:0] reset_val(input int idx);
        return (idx == I_DOW || idx == I_DATE || idx == I_MON) ? 8'h01 : 8'h00;
    endfunction

    // Byte storage: host writes first, otherwise the tick advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= reset_val(i);
        end else if (wr_en) begin
            if (addr < ADDR_W'(NUM_REGS)) regs[addr] <= wr_data;
        end else if (step_en) begin
            for (int i = 0; i < TIME_REGS; i++) regs[i] <= nxt[i];
        end
    end

    // Alarm pulse registered alongside the advance it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) alarm_pulse <= 1'b0;
        else        alarm_pulse <= step_en && hit;
    end

    // Combinational read of the addressed byte.
    assign rd_data = (addr < ADDR_W'(NUM_REGS)) ? regs[addr] : 8'h00;
endmodule

// File: rtl/rtc_calendar_chk.sv
// Property checker for rtc_calendar_core, attached with bind.
module rtc_calendar_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1hz,
    input logic       set_hold,
    input logic       wr_en,
    input logic [7:0] sec_b,
    input logic [7:0] min_b,
    input logic [7:0] hour_b,
    input logic [7:0] date_b,
    input logic       alarm_pulse
);
    logic accepted;
    assign accepted = tick_1hz && !set_hold && !wr_en;

    // R9
    alarm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse |-> $past(accepted));

    // R8
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hold && !wr_en) |=> ($stable(sec_b) && $stable(min_b) && $stable(hour_b)));

    // R3
    sec_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> !$stable(sec_b));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !wr_en) |=> ($stable(sec_b) && $stable(min_b) && $stable(hour_b) && $stable(date_b)));
endmodule

bind rtc_calendar_core rtc_calendar_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_1hz    (tick_1hz),
    .set_hold    (set_hold),
    .wr_en       (wr_en),
    .sec_b       (regs[0]),
    .min_b       (regs[1]),
    .hour_b      (regs[2]),
    .date_b      (regs[4]),
    .alarm_pulse (alarm_pulse)
);

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
    logic       clk = 0, rst_n = 0, tick_1hz = 0, set_hold = 0;
    logic       bin_mode = 0, hr12_mode = 0, wr_en = 0;
    logic [3:0] addr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       alarm_pulse;

    int total = 0, bad = 0, pulses = 0, pend = 0;
    logic [3:0] aq[$];
    logic [7:0] eq[$];
    string      tq[$];

    always #10 clk = ~clk;

    rtc_calendar_core dut (.*);

    // Monitor: pops expected bytes and compares them at falling edges.
    always begin
        @(negedge clk);
        if (pend > 0) begin
            addr = aq[0];
            #1;
            total++;
            if (rd_data !== eq[0]) begin
                bad++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", tq[0], aq[0], rd_data, eq[0]);
            end
            void'(aq.pop_front()); void'(eq.pop_front()); void'(tq.pop_front());
            pend--;
        end
    end

    // Pulse counter, sampled away from the active edge.
    always @(negedge clk) if (rst_n && alarm_pulse) pulses++;

    task automatic expect_reg(input logic [3:0] a, input logic [7:0] e, input string tag);
        aq.push_back(a); eq.push_back(e); tq.push_back(tag);
        pend++;
        wait (pend == 0);
    endtask

    task automatic check_val(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic tick();
        @(negedge clk); tick_1hz = 1;
        @(negedge clk); tick_1hz = 0;
    endtask

    task automatic set_all(input logic [7:0] hr, mn, sc, dw, dt, mo, yr);
        set_hold = 1;
        wr(2, hr); wr(1, mn); wr(0, sc); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, yr);
        set_hold = 0;
    endtask

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        expect_reg(0, 8'h00, "R1 sec"); expect_reg(2, 8'h00, "R1 hour");
        expect_reg(3, 8'h01, "R1 dow"); expect_reg(4, 8'h01, "R1 date");
        expect_reg(5, 8'h01, "R1 month"); expect_reg(9, 8'h00, "R1 alarm hr");
        expect_reg(12, 8'h00, "R1 unmapped");
        check_val("R1 alarm low", alarm_pulse, 0);

        // BCD, 24-hour: end of year rollover
        set_all(8'h23, 8'h59, 8'h58, 8'h07, 8'h31, 8'h12, 8'h99);
        expect_reg(0, 8'h58, "R2 write readback");
        repeat (3) @(negedge clk);
        expect_reg(0, 8'h58, "R2 idle no change");
        tick();
        expect_reg(0, 8'h59, "R3 bcd sec step");
        tick();
        expect_reg(0, 8'h00, "R3 sec wrap"); expect_reg(1, 8'h00, "R3 min wrap");
        expect_reg(2, 8'h00, "R4 hour wrap"); expect_reg(3, 8'h01, "R6 dow wrap");
        expect_reg(4, 8'h01, "R7 date wrap"); expect_reg(5, 8'h01, "R7 month wrap");
        expect_reg(6, 8'h00, "R7 year wrap");

        // R8 hold and write collisions
        set_hold = 1;
        tick();
        expect_reg(0, 8'h00, "R8 hold drops tick");
        wr(0, 8'h10);
        expect_reg(0, 8'h10, "R8 write under hold");
        set_hold = 0;
        @(negedge clk); addr = 0; wr_data = 8'h20; wr_en = 1; tick_1hz = 1;
        @(negedge clk); wr_en = 0; tick_1hz = 0;
        expect_reg(0, 8'h20, "R8 write beats tick");
        expect_reg(1, 8'h00, "R8 no carry on dropped tick");

        // Binary mode
        bin_mode = 1;
        set_all(8'd23, 8'd59, 8'd58, 8'd3, 8'd28, 8'd2, 8'd1);
        tick();
        expect_reg(0, 8'h3B, "R3 binary sec step");
        tick();
        expect_reg(0, 8'h00, "R3 binary sec wrap");
        expect_reg(4, 8'd1, "R7 feb 28 non-leap"); expect_reg(5, 8'd3, "R7 month to 3");
        expect_reg(3, 8'd4, "R6 dow step");
        set_all(8'd23, 8'd59, 8'd59, 8'd1, 8'd28, 8'd2, 8'd4);
        tick();
        expect_reg(4, 8'd29, "R7 leap feb 29"); expect_reg(5, 8'd2, "R7 leap month held");
        set_all(8'd23, 8'd59, 8'd59, 8'd2, 8'd29, 8'd2, 8'd4);
        tick();
        expect_reg(4, 8'd1, "R7 leap feb end"); expect_reg(5, 8'd3, "R7 leap to march");
        set_all(8'd23, 8'd59, 8'd59, 8'd2, 8'd30, 8'd4, 8'd4);
        tick();
        expect_reg(4, 8'd1, "R7 30-day month"); expect_reg(5, 8'd5, "R7 april to may");

        // BCD, 12-hour
        bin_mode = 0; hr12_mode = 1;
        set_all(8'h11, 8'h59, 8'h59, 8'h02, 8'h05, 8'h01, 8'h10);
        tick();
        expect_reg(2, 8'h92, "R5 11AM to 12PM"); expect_reg(4, 8'h05, "R5 noon keeps date");
        wr(1, 8'h59); wr(0, 8'h59);
        tick();
        expect_reg(2, 8'h81, "R5 12PM to 1PM");
        set_all(8'h91, 8'h59, 8'h59, 8'h02, 8'h05, 8'h01, 8'h10);
        tick();
        expect_reg(2, 8'h12, "R5 11PM to 12AM"); expect_reg(4, 8'h06, "R5 midnight date");
        expect_reg(3, 8'h03, "R6 midnight dow");

        // Alarm, 24-hour BCD
        hr12_mode = 0;
        wr(7, 8'h05); wr(8, 8'h10); wr(9, 8'h08);
        set_all(8'h08, 8'h10, 8'h04, 8'h01, 8'h01, 8'h01, 8'h00);
        p0 = pulses;
        tick();
        check_val("R9 pulse due after tick", alarm_pulse, 1);
        repeat (3) @(negedge clk);
        check_val("R9 single pulse", pulses - p0, 1);
        p0 = pulses;
        tick();
        repeat (3) @(negedge clk);
        check_val("R9 no match no pulse", pulses - p0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule